// File: doc/BRIEF.md
# Page memory-type resolver

The block works out the cacheability type of one 4 KiB page of physical memory from a set of programmable range registers. It holds a default-type register, eleven fixed-range registers of eight type bytes each (88 fixed entries covering the first 1 MiB), and `NUM_VAR` variable ranges, each described by a base register and a mask register. A single write port loads any of them, and a combinational read port returns their contents.

A lookup starts when `req_valid` is high while the block is idle. If the global enable is clear, the answer comes straight from the `feature_present` input. If the page lies below 1 MiB and fixed ranges are on, the answer is the fixed entry for that page. In both cases the answer is ready one cycle later. Otherwise the variable ranges are checked one per cycle in index order. The types of all matching ranges are combined by precedence, and the default type is used when none of them match. `done` pulses for one cycle, and `mem_type` then holds the result until the next answer.

Top module: `page_type_resolver`

## Requirements
- R1: After reset `done` and `busy` are 0, `mem_type` is 0, and every register reads back 0.
- R2: When the global enable (bit 11 of the default-type register) is clear, the result is 0 (uncachable) if `feature_present` is 1, and 6 (write-back) if it is 0.
- R3: Fixed entries map pages below 1 MiB as follows. Addresses 0x00000–0x7FFFF use 64 KiB steps and entries 0–7. Addresses 0x80000–0xBFFFF use 16 KiB steps and entries 8–23. Addresses 0xC0000–0xFFFFF use 4 KiB steps and entries 24–87. Fixed register k (select 1+k) holds entry 8k+j in data bits [8j+7:8j].
- R4: When the global enable and the fixed enable (default-type bit 10) are both set and the page number is below 0x100, the fixed entry is returned and the variable ranges are not consulted.
- R5: Variable range i is controlled by two registers. The base register (select 16+2i) holds the start page in bits [PA_W-1:12] and the type in bits [7:0]. The mask register (select 17+2i) holds the mask in bits [PA_W-1:12] and the active flag in bit 11. An inactive range never matches. An active range matches pages p with start ≤ p ≤ (start OR NOT mask), which is the range [start, (start OR NOT mask)+1).
- R6: The types of all matching ranges are merged regardless of order. Identical types keep that type. Any 0 (uncachable) forces 0. A set made only of 4 (write-through) and 6 (write-back) gives 4. Any other mix gives 6.
- R7: With the global enable set, when the fixed path does not apply and no variable range matches, the result is the default type in bits [7:0] of the default-type register (select 0). With fixed ranges off, pages below 1 MiB are resolved through the variable ranges.
- R8: A request on the fixed or disabled path raises `done` one cycle after acceptance. A variable scan raises `done` NUM_VAR+1 cycles after acceptance. `done` is a one-cycle pulse, and `busy` is high throughout a scan.
- R9: A request made while a scan is in progress is ignored: it does not change the result and does not produce an extra `done`.
- R10: Base and mask registers read back only bits below PA_W. Bits at or above PA_W read as 0 even if they were written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select for write |
| wr_data | input | 64 | Write data |
| rd_sel | input | SEL_W | Register select for readback |
| rd_data | output | 64 | Readback data (combinational) |
| req_valid | input | 1 | Lookup request, taken when idle |
| req_page | input | PA_W-12 | Page number to resolve |
| feature_present | input | 1 | Range feature exists; picks the disabled-case result |
| busy | output | 1 | Variable scan in progress |
| done | output | 1 | One-cycle result strobe |
| mem_type | output | 8 | Resolved memory type, held after done |

## Verification
Directed patterns come first. Fixed registers are loaded with each entry's own index, so probing the first and last page of each fixed region shows both the region boundaries and the byte-lane order. Overlapping range pairs are set with each type combination, and uncachable is placed both before and after the other type, which tells the precedence rules apart from a first-match or last-match shortcut. Further directed cases cover an inactive range over the probed page, a range whose base is not aligned to its size (probing just inside and just outside both ends), and fixed mode on and off over the same low page. Random configurations and pages around the 1 MiB boundary are then compared against a model that counts matching types, and every lookup's latency is checked.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

    localparam int FIX_ENTRIES    = 88;
    localparam int FIX_REGS       = FIX_ENTRIES / 8;
    localparam int LOW_PAGES      = 256;
    localparam int DEF_EN_BIT     = 11;
    localparam int DEF_FE_BIT     = 10;
    localparam int MASK_VALID_BIT = 11;
    localparam int SEL_DEF        = 0;
    localparam int SEL_FIX0       = 1;
    localparam int SEL_VAR0       = 16;

    localparam logic [7:0] MT_UC = 8'd0;
    localparam logic [7:0] MT_WT = 8'd4;
    localparam logic [7:0] MT_WB = 8'd6;

    typedef enum logic [0:0] {ST_IDLE, ST_SCAN} state_e;

    // order-independent summary of the matching types seen so far
    typedef struct packed {
        logic       any;
        logic       uc;
        logic       same;
        logic       wtwb;
        logic [7:0] first;
    } merge_t;

    function automatic logic is_wtwb(logic [7:0] t);
        return (t == MT_WT) || (t == MT_WB);
    endfunction

    function automatic merge_t merge_step(merge_t m, logic [7:0] t);
        merge_t r;
        r = m;
        if (!m.any) begin
            r.any   = 1'b1;
            r.first = t;
            r.same  = 1'b1;
            r.uc    = (t == MT_UC);
            r.wtwb  = is_wtwb(t);
        end else begin
            r.same = m.same && (t == m.first);
            r.uc   = m.uc || (t == MT_UC);
            r.wtwb = m.wtwb && is_wtwb(t);
        end
        return r;
    endfunction

    function automatic logic [7:0] merge_final(merge_t m, logic [7:0] dflt);
        if (!m.any)  return dflt;
        if (m.uc)    return MT_UC;
        if (m.same)  return m.first;
        if (m.wtwb)  return MT_WT;
        return MT_WB;
    endfunction

endpackage

// File: rtl/ptr_cfg_regs.sv
module ptr_cfg_regs
    import ptr_pkg::*;
#(
    parameter int NUM_VAR = 4,
    parameter int PA_W    = 36,
    parameter int SEL_W   = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SEL_W-1:0]                   wr_sel,
    input  logic [63:0]                        wr_data,
    input  logic [SEL_W-1:0]                   rd_sel,
    output logic [63:0]                        rd_data,
    output logic                               glob_en,
    output logic                               fix_en,
    output logic [7:0]                         def_type,
    output logic [FIX_REGS-1:0][63:0]          fix_regs,
    output logic [NUM_VAR-1:0][63:0]           var_base,
    output logic [NUM_VAR-1:0][63:0]           var_mask
);

    localparam logic [63:0] PHYS_MASK = (64'd1 << PA_W) - 64'd1;

    typedef struct packed {
        logic                      en;
        logic                      fe;
        logic [7:0]                dtype;
        logic [FIX_REGS-1:0][63:0] fix;
        logic [NUM_VAR-1:0][63:0]  base;
        logic [NUM_VAR-1:0][63:0]  mask;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            if (wr_sel == SEL_W'(SEL_DEF)) begin
                rg_d.en    = wr_data[DEF_EN_BIT];
                rg_d.fe    = wr_data[DEF_FE_BIT];
                rg_d.dtype = wr_data[7:0];
            end
            for (int k = 0; k < FIX_REGS; k++) begin
                if (wr_sel == SEL_W'(SEL_FIX0 + k)) rg_d.fix[k] = wr_data;
            end
            for (int i = 0; i < NUM_VAR; i++) begin
                if (wr_sel == SEL_W'(SEL_VAR0 + 2 * i))     rg_d.base[i] = wr_data;
                // bits above the physical width are implicitly ones
                if (wr_sel == SEL_W'(SEL_VAR0 + 2 * i + 1)) rg_d.mask[i] = wr_data | ~PHYS_MASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rd_data = 64'd0;
        if (rd_sel == SEL_W'(SEL_DEF))
            rd_data = {52'd0, rg_q.en, rg_q.fe, 2'b00, rg_q.dtype};
        for (int k = 0; k < FIX_REGS; k++) begin
            if (rd_sel == SEL_W'(SEL_FIX0 + k)) rd_data = rg_q.fix[k];
        end
        for (int i = 0; i < NUM_VAR; i++) begin
            if (rd_sel == SEL_W'(SEL_VAR0 + 2 * i))     rd_data = rg_q.base[i] & PHYS_MASK;
            if (rd_sel == SEL_W'(SEL_VAR0 + 2 * i + 1)) rd_data = rg_q.mask[i] & PHYS_MASK;
        end
    end

    assign glob_en  = rg_q.en;
    assign fix_en   = rg_q.fe;
    assign def_type = rg_q.dtype;
    assign fix_regs = rg_q.fix;
    assign var_base = rg_q.base;
    assign var_mask = rg_q.mask;

    assert_mask_rb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel >= SEL_W'(SEL_VAR0)) |-> ((rd_data & ~PHYS_MASK) == 64'd0));

endmodule

// File: rtl/ptr_fixed_lookup.sv
module ptr_fixed_lookup
    import ptr_pkg::*;
#(
    parameter int PAGE_W = 24
) (
    input  logic [FIX_REGS-1:0][63:0] fix_regs,
    input  logic [PAGE_W-1:0]         page,
    output logic                      low_page,
    output logic [7:0]                fix_type
);

    logic [7:0] entry_type [FIX_ENTRIES];
    logic [6:0] ent;
    logic [7:0] p8;

    // lay the 88 type bytes out as a flat table
    for (genvar g = 0; g < FIX_ENTRIES; g++) begin : g_ent
        assign entry_type[g] = fix_regs[g / 8][(g % 8) * 8 +: 8];
    end

    assign p8       = page[7:0];
    assign low_page = (page < PAGE_W'(LOW_PAGES));

    always_comb begin
        if (!p8[7])      ent = {4'd0, p8[6:4]};              // 64 KiB steps
        else if (!p8[6]) ent = 7'd8  + {3'd0, p8[5:2]};      // 16 KiB steps
        else             ent = 7'd24 + {1'b0, p8[5:0]};      // 4 KiB steps
    end

    assign fix_type = entry_type[ent];

endmodule

// File: rtl/ptr_var_match.sv
module ptr_var_match
    import ptr_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [63:0]      base,
    input  logic [63:0]      mask,
    input  logic [PA_W-13:0] page,
    output logic             hit,
    output logic [7:0]       rtype
);

    localparam int PAGE_W = PA_W - 12;

    logic [PAGE_W-1:0] start_pg, mask_pg, last_pg;
    logic              unused_bits;

    assign start_pg = base[PA_W-1:12];
    assign mask_pg  = mask[PA_W-1:12];
    assign last_pg  = start_pg | ~mask_pg;
    assign hit      = mask[MASK_VALID_BIT] && (page >= start_pg) && (page <= last_pg);
    assign rtype    = base[7:0];

    assign unused_bits = ^{base[63:PA_W], base[11:8], mask[63:PA_W], mask[10:0]};

endmodule

// File: rtl/page_type_resolver.sv
module page_type_resolver
    import ptr_pkg::*;
#(
    parameter int NUM_VAR = 4,
    parameter int PA_W    = 36,
    parameter int SEL_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [63:0]        wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [63:0]        rd_data,
    input  logic               req_valid,
    input  logic [PA_W-13:0]   req_page,
    input  logic               feature_present,
    output logic               busy,
    output logic               done,
    output logic [7:0]         mem_type
);

    localparam int PAGE_W = PA_W - 12;
    localparam int IDX_W  = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VAR - 1);

    typedef struct packed {
        state_e            state;
        logic [IDX_W-1:0]  idx;
        logic [PAGE_W-1:0] page;
        merge_t            acc;
        logic              done;
        logic [7:0]        mtype;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                      glob_en, fix_en, low_page, vhit;
    logic [7:0]                def_type, fix_type, vtype;
    logic [FIX_REGS-1:0][63:0] fix_regs;
    logic [NUM_VAR-1:0][63:0]  var_base, var_mask;

    ptr_cfg_regs #(.NUM_VAR(NUM_VAR), .PA_W(PA_W), .SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .glob_en(glob_en), .fix_en(fix_en), .def_type(def_type),
        .fix_regs(fix_regs), .var_base(var_base), .var_mask(var_mask)
    );

    ptr_fixed_lookup #(.PAGE_W(PAGE_W)) fixed_i (
        .fix_regs(fix_regs), .page(req_page),
        .low_page(low_page), .fix_type(fix_type)
    );

    // one comparator, stepped across the ranges
    ptr_var_match #(.PA_W(PA_W)) match_i (
        .base(var_base[ctl_q.idx]), .mask(var_mask[ctl_q.idx]),
        .page(ctl_q.page), .hit(vhit), .rtype(vtype)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.page = req_page;
                    if (!glob_en) begin
                        ctl_d.done  = 1'b1;
                        ctl_d.mtype = feature_present ? MT_UC : MT_WB;
                    end else if (fix_en && low_page) begin
                        ctl_d.done  = 1'b1;
                        ctl_d.mtype = fix_type;
                    end else begin
                        ctl_d.state = ST_SCAN;
                        ctl_d.idx   = '0;
                        ctl_d.acc   = '0;
                    end
                end
            end
            ST_SCAN: begin
                if (vhit) ctl_d.acc = merge_step(ctl_q.acc, vtype);
                if (ctl_q.idx == LAST_IDX) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                    ctl_d.mtype = merge_final(ctl_d.acc, def_type);
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy     = (ctl_q.state == ST_SCAN);
    assign done     = ctl_q.done;
    assign mem_type = ctl_q.mtype;

    assert_off_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !glob_en) |=>
        (done && (mem_type == ($past(feature_present) ? MT_UC : MT_WB))));

    assert_fixed_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && glob_en && fix_en && low_page) |=> (done && !busy));

    assert_scan_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && glob_en && !(fix_en && low_page)) |=> (busy && !done));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_uc_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ctl_q.idx == LAST_IDX) && (ctl_q.acc.uc || (vhit && vtype == MT_UC)))
        |=> (done && mem_type == MT_UC));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> (ctl_q.page == $past(ctl_q.page)));

endmodule

// File: tb/page_type_resolver_tb_top.sv
`timescale 1ns/100ps
module page_type_resolver_tb_top;

    localparam int NUM_VAR = 4;
    localparam int PA_W    = 36;
    localparam int SEL_W   = 6;
    localparam int PAGE_W  = PA_W - 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [SEL_W-1:0]  wr_sel = '0;
    logic [63:0]       wr_data = '0;
    logic [SEL_W-1:0]  rd_sel = '0;
    logic [63:0]       rd_data;
    logic              req_valid = 1'b0;
    logic [PAGE_W-1:0] req_page = '0;
    logic              feature_present = 1'b1;
    logic              busy, done;
    logic [7:0]        mem_type;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the register contents
    logic              m_en, m_fe;
    logic [7:0]        m_dt;
    logic [7:0]        m_fix [88];
    logic [PAGE_W-1:0] m_bp [NUM_VAR];
    logic [PAGE_W-1:0] m_mp [NUM_VAR];
    logic [7:0]        m_ty [NUM_VAR];
    logic              m_act [NUM_VAR];

    always #2.5 clk = ~clk;

    page_type_resolver #(.NUM_VAR(NUM_VAR), .PA_W(PA_W), .SEL_W(SEL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .req_valid(req_valid), .req_page(req_page),
        .feature_present(feature_present), .busy(busy), .done(done), .mem_type(mem_type)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int fix_index(input logic [PAGE_W-1:0] p);
        longint a;
        a = longint'(p) * 4096;
        if (a < 64'h80000)      return int'(a / 65536);
        else if (a < 64'hC0000) return 8 + int'((a - 64'h80000) / 16384);
        else                    return 24 + int'((a - 64'hC0000) / 4096);
    endfunction

    function automatic logic [7:0] ref_type(input logic [PAGE_W-1:0] p, input logic feat);
        int cnt [256];
        int kinds;
        int nhit;
        logic [7:0] only;
        if (!m_en) return feat ? 8'd0 : 8'd6;
        if (m_fe && p < 256) return m_fix[fix_index(p)];
        for (int t = 0; t < 256; t++) cnt[t] = 0;
        nhit = 0;
        for (int i = 0; i < NUM_VAR; i++) begin
            if (m_act[i] && p >= m_bp[i] && p <= (m_bp[i] | ~m_mp[i])) begin
                cnt[m_ty[i]]++;
                nhit++;
            end
        end
        if (nhit == 0) return m_dt;
        if (cnt[0] > 0) return 8'd0;
        kinds = 0;
        only = 8'd0;
        for (int t = 0; t < 256; t++) if (cnt[t] > 0) begin kinds++; only = 8'(t); end
        if (kinds == 1) return only;
        if (cnt[4] + cnt[6] == nhit) return 8'd4;
        return 8'd6;
    endfunction

    function automatic int ref_lat(input logic [PAGE_W-1:0] p);
        if (!m_en || (m_fe && p < 256)) return 1;
        return NUM_VAR + 1;
    endfunction

    task automatic wr(input int sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = SEL_W'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_def(input logic en, input logic fe, input logic [7:0] dt);
        m_en = en; m_fe = fe; m_dt = dt;
        wr(0, {52'd0, en, fe, 2'b00, dt});
    endtask

    task automatic set_var(input int i, input logic [PAGE_W-1:0] bp, input logic [7:0] ty,
                           input logic [PAGE_W-1:0] mp, input logic act);
        m_bp[i] = bp; m_ty[i] = ty; m_mp[i] = mp; m_act[i] = act;
        wr(16 + 2 * i, {28'd0, bp, 4'd0, ty});
        wr(17 + 2 * i, {28'd0, mp, act, 11'd0});
    endtask

    task automatic clear_vars();
        for (int i = 0; i < NUM_VAR; i++) set_var(i, '0, 8'd0, '0, 1'b0);
    endtask

    task automatic lookup(input logic [PAGE_W-1:0] p, input logic feat, input logic inject,
                          output logic [7:0] t, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_page = p; feature_present = feat;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            if (inject && lat == 1) begin
                req_valid = 1'b1; req_page = p ^ 24'h1;
            end
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
        end
        t = mem_type;
    endtask

    task automatic probe(input logic [PAGE_W-1:0] p, input logic feat, input string tag);
        logic [7:0] t;
        int lat;
        logic [7:0] e;
        e = ref_type(p, feat);
        lookup(p, feat, 1'b0, t, lat);
        chk(t == e, tag, t, e);
        chk(lat == ref_lat(p), {tag, " R8 latency"}, lat, ref_lat(p));
    endtask

    task automatic probe_exp(input logic [PAGE_W-1:0] p, input logic [7:0] e, input string tag);
        logic [7:0] t;
        int lat;
        lookup(p, 1'b1, 1'b0, t, lat);
        chk(t == e, tag, t, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] t;
        int lat;
        void'($urandom(32'h00C0FFEE));
        m_en = 0; m_fe = 0; m_dt = 0;
        for (int e = 0; e < 88; e++) m_fix[e] = 8'd0;
        for (int i = 0; i < NUM_VAR; i++) begin
            m_bp[i] = '0; m_mp[i] = '0; m_ty[i] = '0; m_act[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(done == 1'b0 && busy == 1'b0, "R1 done/busy after reset", {done, busy}, 0);
        chk(mem_type == 8'd0, "R1 mem_type after reset", mem_type, 0);
        rd_sel = 6'd17; #1;
        chk(rd_data == 64'd0, "R1 mask0 readback", rd_data, 0);
        rd_sel = 6'd0; #1;
        chk(rd_data == 64'd0, "R1 default readback", rd_data, 0);

        // R2 globally disabled
        probe_exp(24'h345, 8'd0, "R2 disabled with feature");
        lookup(24'h345, 1'b0, 1'b0, t, lat);
        chk(t == 8'd6, "R2 disabled without feature", t, 6);
        chk(lat == 1, "R8 disabled latency", lat, 1);

        // R3 fixed table: each entry holds its own index
        for (int k = 0; k < 11; k++) begin
            logic [63:0] d;
            for (int j = 0; j < 8; j++) begin
                d[8*j +: 8] = 8'(8 * k + j);
                m_fix[8 * k + j] = 8'(8 * k + j);
            end
            wr(1 + k, d);
        end
        set_def(1'b1, 1'b1, 8'd5);
        probe_exp(24'h00, 8'd0,  "R3 first page");
        probe_exp(24'h7F, 8'd7,  "R3 end of 64K region");
        probe_exp(24'h80, 8'd8,  "R3 start of 16K region");
        probe_exp(24'h87, 8'd9,  "R3 second 16K step");
        probe_exp(24'hBF, 8'd23, "R3 end of 16K region");
        probe_exp(24'hC0, 8'd24, "R3 start of 4K region");
        probe_exp(24'hFF, 8'd87, "R3 last fixed page");

        // R4 fixed wins over variable
        set_var(0, 24'h010, 8'd0, 24'hFFFFF0, 1'b1);
        lookup(24'h012, 1'b1, 1'b0, t, lat);
        chk(t == 8'd1, "R4 fixed overrides variable", t, 1);
        chk(lat == 1, "R4 R8 fixed latency", lat, 1);
        // R7 fixed disabled -> variable path in low region
        set_def(1'b1, 1'b0, 8'd5);
        lookup(24'h012, 1'b1, 1'b0, t, lat);
        chk(t == 8'd0, "R7 low page via variable", t, 0);
        chk(lat == NUM_VAR + 1, "R8 scan latency", lat, NUM_VAR + 1);
        probe_exp(24'h100, 8'd5, "R7 default on miss");
        set_def(1'b1, 1'b1, 8'd5);
        probe_exp(24'h100, 8'd5, "R7 default above fixed region");

        // R5 inactive range and unaligned span
        clear_vars();
        set_var(1, 24'h200, 8'd0, 24'hFFFF00, 1'b0);
        probe_exp(24'h210, 8'd5, "R5 inactive range ignored");
        set_var(2, 24'h105, 8'd4, 24'hFFFFFC, 1'b1);
        probe_exp(24'h104, 8'd5, "R5 below start");
        probe_exp(24'h105, 8'd4, "R5 at start");
        probe_exp(24'h107, 8'd4, "R5 last page");
        probe_exp(24'h108, 8'd5, "R5 past end");

        // R6 merge rules over a shared page 0x200
        clear_vars();
        set_var(0, 24'h200, 8'd4, 24'hFFFFF0, 1'b1);
        set_var(3, 24'h200, 8'd6, 24'hFFFF00, 1'b1);
        probe_exp(24'h201, 8'd4, "R6 WT+WB gives WT");
        probe_exp(24'h250, 8'd6, "R6 single WB");
        set_var(0, 24'h200, 8'd6, 24'hFFFFF0, 1'b1);
        probe_exp(24'h201, 8'd6, "R6 identical types");
        set_var(0, 24'h200, 8'd1, 24'hFFFFF0, 1'b1);
        probe_exp(24'h201, 8'd6, "R6 other mix gives WB");
        set_var(0, 24'h200, 8'd0, 24'hFFFFF0, 1'b1);
        set_var(3, 24'h200, 8'd1, 24'hFFFF00, 1'b1);
        probe_exp(24'h201, 8'd0, "R6 UC first wins");
        set_var(0, 24'h200, 8'd5, 24'hFFFFF0, 1'b1);
        set_var(3, 24'h200, 8'd0, 24'hFFFF00, 1'b1);
        probe_exp(24'h201, 8'd0, "R6 UC last wins");
        set_var(1, 24'h200, 8'd4, 24'hFFFFF0, 1'b1);
        probe_exp(24'h201, 8'd0, "R6 UC among three");

        // R9 request during scan
        lookup(24'h201, 1'b1, 1'b1, t, lat);
        chk(t == 8'd0, "R9 result unaffected", t, 0);
        chk(lat == NUM_VAR + 1, "R9 latency unaffected", lat, NUM_VAR + 1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0, "R9 no extra done", {done, busy}, 0);
        end

        // R10 mask readback drops high bits
        wr(19, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_sel = 6'd19; #1;
        chk(rd_data == 64'h0000_000F_FFFF_FFFF, "R10 mask readback", rd_data, 64'h0000_000F_FFFF_FFFF);
        wr(18, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_sel = 6'd18; #1;
        chk(rd_data == 64'h0000_000F_FFFF_FFFF, "R10 base readback", rd_data, 64'h0000_000F_FFFF_FFFF);
        set_var(1, 24'h0, 8'd0, 24'h0, 1'b0);

        // random configurations
        for (int cfg = 0; cfg < 4; cfg++) begin
            logic [7:0] tys [5];
            tys[0] = 8'd0; tys[1] = 8'd1; tys[2] = 8'd4; tys[3] = 8'd5; tys[4] = 8'd6;
            set_def(($urandom % 8) != 0, $urandom % 2, tys[$urandom % 5]);
            for (int k = 0; k < 11; k++) begin
                logic [63:0] d;
                for (int j = 0; j < 8; j++) begin
                    d[8*j +: 8] = tys[$urandom % 5];
                    m_fix[8 * k + j] = d[8*j +: 8];
                end
                wr(1 + k, d);
            end
            for (int i = 0; i < NUM_VAR; i++) begin
                int sz;
                logic [PAGE_W-1:0] bp;
                sz = 1 << ($urandom % 6);
                bp = PAGE_W'(256 + (($urandom % 64) & ~(sz - 1)));
                if ($urandom % 4 == 0) bp = PAGE_W'(($urandom % 256) & ~(sz - 1));
                set_var(i, bp, tys[$urandom % 5], ~PAGE_W'(sz - 1), ($urandom % 4) != 0);
            end
            for (int n = 0; n < 80; n++) begin
                logic [PAGE_W-1:0] p;
                p = ($urandom % 2 == 1) ? PAGE_W'($urandom % 512) : PAGE_W'(256 + $urandom % 96);
                probe(p, $urandom % 2, "R6 R7 random lookup");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule